// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by reading translation descriptors from memory. A request carries the virtual address. The walker first fetches a level-one descriptor from a table whose base comes from the `ttb_base` input. That descriptor does one of three things:

- maps a 1 MB section and ends the walk;
- points to a level-two table, from which a second descriptor is fetched; or
- reports a fault.

A level-two descriptor maps either a 64 KB page or a 4 KB page, or reports a fault. Each mapping size keeps its own number of virtual offset bits when the physical address is assembled.

Only one walk is in flight at a time. The walker owns a single-outstanding descriptor read port. It presents its result (physical address plus fault flag) on a valid/ready port and holds it there until the result is taken.

The controller has six named states:

| State | Meaning |
|---|---|
| IDLE | Waiting for a request |
| L1_REQ | Issuing the level-one fetch |
| L1_WAIT | Awaiting the level-one data |
| L2_REQ | Issuing the level-two fetch |
| L2_WAIT | Awaiting the level-two data |
| DONE | Result held on the result port |

The transitions are:

- **accept**: IDLE to L1_REQ, on `req_valid`.
- **l1_grant**: L1_REQ to L1_WAIT, on `mem_req_ready`.
- **descend**: L1_WAIT to L2_REQ, on a table-pointer descriptor.
- **l1_finish**: L1_WAIT to DONE, on a section or fault descriptor.
- **l2_grant**: L2_REQ to L2_WAIT, on `mem_req_ready`.
- **l2_finish**: L2_WAIT to DONE, on any response.
- **retire**: DONE to IDLE, on `res_ready`.

Top module: `ptw_walker`

## Requirements
- R1: After reset, `req_ready` is 1 and both `mem_req_valid` and `res_valid` are 0.
- R2: The level-one fetch address is {ttb_base[17:0], VA[31:20], 2'b00}.
- R3: A level-one descriptor with bits[1:0]=10 ends the walk with no further fetch, and gives fault 0 and PA = {desc[31:20], VA[19:0]}.
- R4: A level-one descriptor with bits[1:0]=01 causes a level-two fetch at {desc1[31:10], VA[19:12], 2'b00}.
- R5: A level-two descriptor with bits[1:0]=01 gives fault 0 and PA = {desc2[31:16], VA[15:0]}.
- R6: A level-two descriptor with bit[1]=1 (codes 10 and 11) gives fault 0 and PA = {desc2[31:12], VA[11:0]}.
- R7: A level-one descriptor with bits[1:0] of 00 or 11 ends the walk with fault 1 and PA 0, and issues no level-two fetch.
- R8: A level-two descriptor with bits[1:0]=00 ends the walk with fault 1 and PA 0.
- R9: `req_ready` is 0 from the cycle after a request is accepted until the result is taken, and requests offered in that time are ignored.
- R10: While `res_valid` is 1 and `res_ready` is 0, `res_valid`, `res_pa` and `res_fault` stay unchanged.
- R11: While `mem_req_valid` is 1 and `mem_req_ready` is 0, the request and its address stay unchanged; `mem_req_valid` and `res_valid` are never 1 together.
- R12: `mem_rsp_valid` is ignored unless a fetch has been granted and its data is still awaited.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ttb_base | input | 18 | Level-one table base, 16 KB aligned |
| req_valid | input | 1 | Translation request offered |
| req_ready | output | 1 | Walker idle and able to accept |
| req_va | input | 32 | Virtual address to translate |
| mem_req_valid | output | 1 | Descriptor fetch requested |
| mem_req_ready | input | 1 | Memory accepts the fetch |
| mem_req_addr | output | 32 | Byte address of the descriptor |
| mem_rsp_valid | input | 1 | Descriptor data returned |
| mem_rsp_data | input | 32 | Descriptor word |
| res_valid | output | 1 | Translation result available |
| res_ready | input | 1 | Consumer takes the result |
| res_pa | output | 32 | Physical address, 0 on fault |
| res_fault | output | 1 | Walk ended on a fault descriptor |

## Verification
The properties assume the environment follows the handshakes:

- memory returns exactly one response per granted fetch;
- `ttb_base` stays steady while a walk is active;
- the consumer drops `res_ready` once a result has been taken.

The stimulus stays within these assumptions. A single task drives each walk. It returns one response after each grant, with random stall and response delays. It holds the base steady for the whole walk. It injects stray responses only during the request phase and junk requests only while busy. Random walks cover every descriptor type code at both levels, and directed walks pin each code once.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
    localparam int ADDR_W    = 32;
    localparam int DESC_W    = 32;
    localparam int L1_IDX_W  = 12;
    localparam int L2_IDX_W  = 8;
    localparam int BYTE_W    = 2;
    localparam int TTB_W     = ADDR_W - L1_IDX_W - BYTE_W;
    localparam int CPT_W     = ADDR_W - L2_IDX_W - BYTE_W;
    localparam int SEC_OFF_W = ADDR_W - L1_IDX_W;
    localparam int LRG_OFF_W = 16;
    localparam int SML_OFF_W = SEC_OFF_W - L2_IDX_W;

    typedef enum logic [2:0] {
        DK_FAULT,
        DK_TABLE,
        DK_SECTION,
        DK_LARGE,
        DK_SMALL
    } desc_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_L1_REQ,
        ST_L1_WAIT,
        ST_L2_REQ,
        ST_L2_WAIT,
        ST_DONE
    } walk_state_e;
endpackage

// File: rtl/ptw_desc_decode.sv
module ptw_desc_decode
    import ptw_pkg::*;
#(
    parameter int LEVEL = 1
) (
    input  logic [DESC_W-1:0] desc,
    output desc_kind_e        kind
);
    logic unused_hi;
    assign unused_hi = ^desc[DESC_W-1:2];

    generate
        if (LEVEL == 1) begin : g_first
            always_comb begin
                unique case (desc[1:0])
                    2'b01:   kind = DK_TABLE;
                    2'b10:   kind = DK_SECTION;
                    default: kind = DK_FAULT;
                endcase
            end
        end else begin : g_second
            always_comb begin
                unique case (desc[1:0])
                    2'b00:   kind = DK_FAULT;
                    2'b01:   kind = DK_LARGE;
                    default: kind = DK_SMALL;
                endcase
            end
        end
    endgenerate
endmodule

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen
    import ptw_pkg::*;
(
    input  logic [TTB_W-1:0]  ttb,
    input  logic [ADDR_W-1:0] va,
    input  logic [DESC_W-1:0] l1_desc,
    input  logic              second,
    output logic [ADDR_W-1:0] addr
);
    logic [ADDR_W-1:0] l1_addr;
    logic [ADDR_W-1:0] l2_addr;
    logic              unused_bits;

    assign l1_addr = {ttb, va[ADDR_W-1 -: L1_IDX_W], {BYTE_W{1'b0}}};
    assign l2_addr = {l1_desc[DESC_W-1 -: CPT_W],
                      va[SEC_OFF_W-1 -: L2_IDX_W], {BYTE_W{1'b0}}};
    assign addr    = second ? l2_addr : l1_addr;

    assign unused_bits = ^{va[SML_OFF_W-1:0], l1_desc[DESC_W-CPT_W-1:0]};
endmodule

// File: rtl/ptw_pa_build.sv
module ptw_pa_build
    import ptw_pkg::*;
(
    input  desc_kind_e        kind,
    input  logic [DESC_W-1:0] desc,
    input  logic [ADDR_W-1:0] va,
    output logic [ADDR_W-1:0] pa
);
    logic unused_bits;
    assign unused_bits = ^{desc[SML_OFF_W-1:0], va[ADDR_W-1:SEC_OFF_W]};

    always_comb begin
        unique case (kind)
            DK_SECTION: pa = {desc[DESC_W-1:SEC_OFF_W], va[SEC_OFF_W-1:0]};
            DK_LARGE:   pa = {desc[DESC_W-1:LRG_OFF_W], va[LRG_OFF_W-1:0]};
            DK_SMALL:   pa = {desc[DESC_W-1:SML_OFF_W], va[SML_OFF_W-1:0]};
            default:    pa = '0;
        endcase
    end
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
    import ptw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [17:0]       ttb_base,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [31:0]       req_va,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [31:0]       mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [31:0]       mem_rsp_data,
    output logic              res_valid,
    input  logic              res_ready,
    output logic [31:0]       res_pa,
    output logic              res_fault
);
    walk_state_e       state_q, state_d;
    logic [ADDR_W-1:0] va_q;
    logic [DESC_W-1:0] l1_desc_q;
    logic [ADDR_W-1:0] pa_q;
    logic              fault_q;
    desc_kind_e        kind_l1, kind_l2, kind_sel;
    logic [ADDR_W-1:0] pa_new;

    ptw_desc_decode #(.LEVEL(1)) u_dec_l1 (.desc(mem_rsp_data), .kind(kind_l1));
    ptw_desc_decode #(.LEVEL(2)) u_dec_l2 (.desc(mem_rsp_data), .kind(kind_l2));

    assign kind_sel = (state_q == ST_L2_WAIT) ? kind_l2 : kind_l1;

    ptw_pa_build u_pa (.kind(kind_sel), .desc(mem_rsp_data), .va(va_q), .pa(pa_new));

    ptw_addr_gen u_addr (
        .ttb     (ttb_base),
        .va      (va_q),
        .l1_desc (l1_desc_q),
        .second  (state_q == ST_L2_REQ),
        .addr    (mem_req_addr)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (req_valid)     state_d = ST_L1_REQ;
            ST_L1_REQ:  if (mem_req_ready) state_d = ST_L1_WAIT;
            ST_L1_WAIT: if (mem_rsp_valid)
                            state_d = (kind_l1 == DK_TABLE) ? ST_L2_REQ : ST_DONE;
            ST_L2_REQ:  if (mem_req_ready) state_d = ST_L2_WAIT;
            ST_L2_WAIT: if (mem_rsp_valid) state_d = ST_DONE;
            ST_DONE:    if (res_ready)     state_d = ST_IDLE;
            default:                       state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        req_ready     = 1'b0;
        mem_req_valid = 1'b0;
        res_valid     = 1'b0;
        unique case (state_q)
            ST_IDLE:              req_ready     = 1'b1;
            ST_L1_REQ, ST_L2_REQ: mem_req_valid = 1'b1;
            ST_DONE:              res_valid     = 1'b1;
            default: ;
        endcase
    end

    assign res_pa    = pa_q;
    assign res_fault = fault_q;

    // walk datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            va_q      <= '0;
            l1_desc_q <= '0;
            pa_q      <= '0;
            fault_q   <= 1'b0;
        end else begin
            if (state_q == ST_IDLE && req_valid) begin
                va_q <= req_va;
            end
            if (state_q == ST_L1_WAIT && mem_rsp_valid) begin
                l1_desc_q <= mem_rsp_data;
                pa_q      <= pa_new;
                fault_q   <= (kind_l1 == DK_FAULT);
            end
            if (state_q == ST_L2_WAIT && mem_rsp_valid) begin
                pa_q    <= pa_new;
                fault_q <= (kind_l2 == DK_FAULT);
            end
        end
    end
endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_ready,
    input logic        mem_req_valid,
    input logic        mem_req_ready,
    input logic [31:0] mem_req_addr,
    input logic        res_valid,
    input logic        res_ready,
    input logic [31:0] res_pa,
    input logic        res_fault
);
    // R9
    busy_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R9
    busy_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> !req_ready);

    // R10
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_ready) |=> (res_valid && $stable(res_pa) && $stable(res_fault)));

    // R11
    fetch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    // R11
    fetch_result_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_req_valid && res_valid));

    // R7
    fault_pa_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_fault) |-> (res_pa == 32'd0));
endmodule

bind ptw_walker ptw_walker_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .res_valid     (res_valid),
    .res_ready     (res_ready),
    .res_pa        (res_pa),
    .res_fault     (res_fault)
);

// File: tb/ptw_walker_tb.sv
module ptw_walker_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [17:0] ttb_base = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_va = '0;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        res_valid;
    logic        res_ready = 1'b0;
    logic [31:0] res_pa;
    logic        res_fault;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    ptw_walker u_dut (.*);

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // expected model from the requirements
    function automatic void model(input logic [31:0] va, input logic [17:0] tb,
                                  input logic [31:0] d1, input logic [31:0] d2,
                                  output logic [31:0] a1, output logic [31:0] a2,
                                  output bit need2, output logic [31:0] pa, output bit flt);
        a1 = {tb, va[31:20], 2'b00};
        a2 = {d1[31:10], va[19:12], 2'b00};
        need2 = (d1[1:0] == 2'b01);
        pa = 32'd0;
        flt = 1'b1;
        if (d1[1:0] == 2'b10) begin
            pa = {d1[31:20], va[19:0]}; flt = 1'b0;
        end else if (need2) begin
            if (d2[1:0] == 2'b01)   begin pa = {d2[31:16], va[15:0]}; flt = 1'b0; end
            else if (d2[1] == 1'b1) begin pa = {d2[31:12], va[11:0]}; flt = 1'b0; end
        end
    endfunction

    task automatic serve_fetch(input logic [31:0] exp_addr, input logic [31:0] data, input string tag);
        int n = 0;
        while (!mem_req_valid && n < 10) begin @(negedge clk); n++; end
        chk(mem_req_valid, {tag, " fetch issued"}, {31'd0, mem_req_valid}, 32'd1);
        chk(mem_req_addr == exp_addr, {tag, " fetch address"}, mem_req_addr, exp_addr);
        repeat ($urandom % 3) begin
            // R12: stray response before grant must be ignored
            mem_rsp_valid = 1'b1; mem_rsp_data = $urandom;
            @(negedge clk);
        end
        mem_rsp_valid = 1'b0;
        mem_req_ready = 1'b1;
        @(negedge clk);
        mem_req_ready = 1'b0;
        repeat ($urandom % 3) @(negedge clk);
        mem_rsp_valid = 1'b1; mem_rsp_data = data;
        @(negedge clk);
        mem_rsp_valid = 1'b0; mem_rsp_data = $urandom;
    endtask

    task automatic run_walk(input logic [31:0] va, input logic [17:0] tb,
                            input logic [31:0] d1, input logic [31:0] d2, input string tag);
        logic [31:0] a1, a2, epa;
        bit need2, eflt;
        logic [31:0] held;
        int n = 0;
        model(va, tb, d1, d2, a1, a2, need2, epa, eflt);
        @(negedge clk);
        ttb_base = tb; req_va = va; req_valid = 1'b1;
        chk(req_ready, "R9 ready when idle", {31'd0, req_ready}, 32'd1);
        @(negedge clk);
        req_valid = 1'b0; req_va = $urandom;
        chk(!req_ready, "R9 busy after accept", {31'd0, req_ready}, 32'd0);
        serve_fetch(a1, d1, "R2");
        if (need2) serve_fetch(a2, d2, "R4");
        while (!res_valid && n < 10) begin @(negedge clk); n++; end
        chk(res_valid, {tag, " result valid"}, {31'd0, res_valid}, 32'd1);
        chk(!mem_req_valid, "R7 no extra fetch", {31'd0, mem_req_valid}, 32'd0);
        held = res_pa;
        repeat ($urandom % 3) begin
            req_valid = 1'b1; req_va = $urandom;
            chk(!req_ready, "R9 no accept while busy", {31'd0, req_ready}, 32'd0);
            @(negedge clk);
            chk(res_valid && res_pa == held, "R10 result held", res_pa, held);
        end
        chk(res_pa == epa, {tag, " pa"}, res_pa, epa);
        chk(res_fault == eflt, {tag, " fault"}, {31'd0, res_fault}, {31'd0, eflt});
        req_valid = 1'b0;
        res_ready = 1'b1;
        @(negedge clk);
        res_ready = 1'b0;
        chk(!res_valid && req_ready, "R9 idle after retire", {30'd0, res_valid, req_ready}, 32'd1);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && !mem_req_valid && !res_valid, "R1 reset state",
            {29'd0, req_ready, mem_req_valid, res_valid}, 32'd4);

        // directed corner cases
        run_walk(32'hABCD_1234, 18'h2_5A5A, 32'h7650_0002, 32'h0, "R3 section");
        run_walk(32'h1234_5678, 18'h0_0001, 32'hCAFE_0401, 32'h9876_0001, "R5 large page");
        run_walk(32'hFFFF_FFFF, 18'h3_FFFF, 32'hFFFF_FC01, 32'h1357_9002, "R6 small page 10");
        run_walk(32'h0000_0000, 18'h0_0000, 32'h0000_0001, 32'hAAAA_B003, "R6 small page 11");
        run_walk(32'h8765_4321, 18'h1_1111, 32'hFFF0_0000, 32'h0, "R7 L1 fault 00");
        run_walk(32'h4444_5555, 18'h2_2222, 32'h1230_0003, 32'h0, "R7 L1 fault 11");
        run_walk(32'h5A5A_A5A5, 18'h0_F0F0, 32'h0ACE_0001, 32'hFFFF_FFFC, "R8 L2 fault");

        // constrained random walks
        for (int i = 0; i < 150; i++) begin
            logic [31:0] d1 = $urandom;
            logic [31:0] d2 = $urandom;
            if (i % 2 == 0) d1[1:0] = 2'b01;
            run_walk($urandom, 18'($urandom), d1, d2, "R3 R5 R6 R7 R8 random");
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule